// File: doc/BRIEF.md
# Sequential Multiply-Accumulate Low-Pass FIR

This block is a 31-tap low-pass FIR filter for signed 8-bit audio samples. Samples arrive on a one-cycle strobe that is much slower than the system clock. A single multiplier is reused over successive clock cycles, so the filter needs only one multiplier and one adder instead of one per tap. Each new sample goes into a 32-entry register ring. A 5-bit pointer that wraps by itself addresses the ring, so no bounds logic is needed.

The coefficients are signed 10-bit integers, equal to the filter weights scaled by 1024. A combinational lookup indexed by the tap number supplies them. The sum is kept in an 18-bit signed accumulator. When all taps have been added, the sum is copied to the output register. It stays there until the next completed sum, so downstream the filter looks like a one-sample delay.

Top module: `fir_seq_lowpass`

## Requirements
- R1: While `rst` is high on a clock edge, the sample history is cleared to zero, the engine goes idle and `filt_out` becomes 0.
- R2: A clock edge with `sample_stb` high advances the ring pointer by one, modulo 32. The same edge writes `sample_in` at the new pointer position and clears both the accumulator and the tap counter.
- R3: The multiplication is signed: both the sample and the coefficient are two's complement. On the 31 edges after a strobe, the engine adds one product c[k]·x[n−k] per edge, for k = 0 to 30.
- R4: The completed sum is loaded into `filt_out` on the 32nd edge after the strobe edge. It equals the sum of c[k]·x[n−k] over k = 0..30. Samples never written count as zero, and samples more than 30 strobes old have no effect.
- R5: The coefficients are symmetric: c[k] = c[30−k]. For k = 0 to 15 they are −1, −1, −2, −3, −4, −3, 0, 6, 15, 27, 42, 58, 73, 85, 94, 97. The lookup returns 0 for tap number 31.
- R6: `filt_out` changes only on the edge that loads a completed sum. On every other edge it holds its value, including the edges of an ongoing accumulation.
- R7: A unit impulse followed by zeros gives the outputs c[0]..c[30] in tap order, then zero. An impulse of −128 gives −128·c[k].
- R8: A strobe may land on the same edge that loads a completed sum. On that edge the completed sum still reaches `filt_out`, and the new sample starts its own accumulation.
- R9: A strobe that arrives while an accumulation is still running discards the partial sum and leaves `filt_out` unchanged. The interrupted sample stays in the history and is used by later sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | One-cycle strobe: a new sample is present on `sample_in` |
| sample_in | input | 8 | New sample, signed two's complement |
| filt_out | output | 18 | Filter result, signed, scaled by 1024, held between loads |

## Verification
Two events can fall on the same edge: loading a completed sum into the output, and accepting a new sample. The bench provokes this by raising the strobe exactly 32 edges after the previous strobe edge. It then checks that `filt_out` shows the finished sum of the earlier sample, and that the later sample's own sum appears 32 edges after that. It also drives a strobe ten cycles into an accumulation. There it checks that the output keeps its old value, and that the interrupted sample still shows up in the next computed sum.

// File: rtl/fir_pkg.sv
package fir_pkg;

    localparam int SAMPLE_W = 8;
    localparam int COEF_W   = 10;
    localparam int ACC_W    = 18;
    localparam int N_TAPS   = 31;
    localparam int RING_N   = 32;

    // Half of a symmetric low-pass kernel, index 0 (outer) to 15 (centre).
    function automatic logic signed [COEF_W-1:0] half_kernel(input int k);
        case (k)
            0:  half_kernel = -10'sd1;
            1:  half_kernel = -10'sd1;
            2:  half_kernel = -10'sd2;
            3:  half_kernel = -10'sd3;
            4:  half_kernel = -10'sd4;
            5:  half_kernel = -10'sd3;
            6:  half_kernel = 10'sd0;
            7:  half_kernel = 10'sd6;
            8:  half_kernel = 10'sd15;
            9:  half_kernel = 10'sd27;
            10: half_kernel = 10'sd42;
            11: half_kernel = 10'sd58;
            12: half_kernel = 10'sd73;
            13: half_kernel = 10'sd85;
            14: half_kernel = 10'sd94;
            15: half_kernel = 10'sd97;
            default: half_kernel = 10'sd0;
        endcase
    endfunction

endpackage

// File: rtl/fir_coef_rom.sv
module fir_coef_rom #(
    parameter int TAPS  = fir_pkg::N_TAPS,
    parameter int IDX_W = $clog2(TAPS + 1),
    parameter int CW    = fir_pkg::COEF_W
) (
    input  logic [IDX_W-1:0]     tap_idx,
    output logic signed [CW-1:0] coef
);
    localparam int MID = (TAPS - 1) / 2;

    always_comb begin
        int k;
        k = int'(tap_idx);
        if (k >= TAPS) begin
            coef = '0;
        end else if (k <= MID) begin
            coef = CW'(fir_pkg::half_kernel(k));
        end else begin
            coef = CW'(fir_pkg::half_kernel(TAPS - 1 - k));
        end
    end
endmodule

// File: rtl/fir_hist_ring.sv
module fir_hist_ring #(
    parameter int DEPTH = fir_pkg::RING_N,
    parameter int SW    = fir_pkg::SAMPLE_W,
    parameter int IDX_W = 5,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_stb,
    input  logic signed [SW-1:0] wr_data,
    input  logic [IDX_W-1:0]     age,
    output logic signed [SW-1:0] rd_data,
    output logic [PTR_W-1:0]     head_ptr,
    output logic signed [SW-1:0] head_data
);
    logic signed [SW-1:0] hist_q [DEPTH];
    logic signed [SW-1:0] hist_d [DEPTH];
    logic [PTR_W-1:0]     ptr_q, ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        for (int i = 0; i < DEPTH; i++) hist_d[i] = hist_q[i];
        if (wr_stb) begin
            ptr_d         = ptr_q + PTR_W'(1);
            hist_d[ptr_d] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else begin
            ptr_q <= ptr_d;
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= hist_d[i];
        end
    end

    assign rd_data   = hist_q[ptr_q - PTR_W'(age)];
    assign head_ptr  = ptr_q;
    assign head_data = hist_q[ptr_q];
endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit #(
    parameter int TAPS  = fir_pkg::N_TAPS,
    parameter int SW    = fir_pkg::SAMPLE_W,
    parameter int CW    = fir_pkg::COEF_W,
    parameter int AW    = fir_pkg::ACC_W,
    parameter int IDX_W = $clog2(TAPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic signed [SW-1:0] smp,
    input  logic signed [CW-1:0] coef,
    output logic [IDX_W-1:0]     tap_idx,
    output logic                 busy,
    output logic signed [AW-1:0] acc,
    output logic signed [AW-1:0] y
);
    localparam int PW = SW + CW;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TAPS);

    typedef struct packed {
        logic signed [AW-1:0] acc;
        logic signed [AW-1:0] y;
        logic [IDX_W-1:0]     idx;
        logic                 busy;
    } mac_st_t;

    mac_st_t st_q, st_d;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;
    logic                 finishing;

    assign prod      = smp * coef;
    assign prod_ext  = AW'(prod);
    assign finishing = st_q.busy && (st_q.idx == LAST);

    always_comb begin
        st_d = st_q;
        if (finishing) begin
            st_d.y    = st_q.acc;
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.acc = st_q.acc + prod_ext;
            st_d.idx = st_q.idx + IDX_W'(1);
        end
        if (start) begin
            st_d.acc  = '0;
            st_d.idx  = '0;
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tap_idx = st_q.idx;
    assign busy    = st_q.busy;
    assign acc     = st_q.acc;
    assign y       = st_q.y;
endmodule

// File: rtl/fir_seq_lowpass.sv
module fir_seq_lowpass #(
    parameter int TAPS  = fir_pkg::N_TAPS,
    parameter int DEPTH = fir_pkg::RING_N,
    parameter int SW    = fir_pkg::SAMPLE_W,
    parameter int CW    = fir_pkg::COEF_W,
    parameter int AW    = fir_pkg::ACC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_stb,
    input  logic signed [SW-1:0] sample_in,
    output logic signed [AW-1:0] filt_out
);
    localparam int IDX_W = $clog2(TAPS + 1);
    localparam int PTR_W = $clog2(DEPTH);

    logic [IDX_W-1:0]     tap_idx;
    logic signed [CW-1:0] coef;
    logic signed [SW-1:0] tap_smp;
    logic [PTR_W-1:0]     head_ptr;
    logic signed [SW-1:0] head_data;
    logic                 busy;
    logic signed [AW-1:0] acc;

    fir_coef_rom #(.TAPS(TAPS), .IDX_W(IDX_W), .CW(CW)) u_rom (
        .tap_idx (tap_idx),
        .coef    (coef)
    );

    fir_hist_ring #(.DEPTH(DEPTH), .SW(SW), .IDX_W(IDX_W)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .wr_stb    (sample_stb),
        .wr_data   (sample_in),
        .age       (tap_idx),
        .rd_data   (tap_smp),
        .head_ptr  (head_ptr),
        .head_data (head_data)
    );

    fir_mac_unit #(.TAPS(TAPS), .SW(SW), .CW(CW), .AW(AW), .IDX_W(IDX_W)) u_mac (
        .clk     (clk),
        .rst     (rst),
        .start   (sample_stb),
        .smp     (tap_smp),
        .coef    (coef),
        .tap_idx (tap_idx),
        .busy    (busy),
        .acc     (acc),
        .y       (filt_out)
    );
endmodule

// File: rtl/fir_seq_lowpass_chk.sv
module fir_seq_lowpass_chk #(
    parameter int SW    = 8,
    parameter int AW    = 18,
    parameter int IDX_W = 5,
    parameter int PTR_W = 5,
    parameter int TAPS  = 31
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sample_stb,
    input logic signed [SW-1:0] sample_in,
    input logic [PTR_W-1:0]     head_ptr,
    input logic signed [SW-1:0] head_data,
    input logic [IDX_W-1:0]     tap_idx,
    input logic                 busy,
    input logic signed [AW-1:0] acc,
    input logic signed [AW-1:0] filt_out
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TAPS);

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> head_ptr == PTR_W'($past(head_ptr) + PTR_W'(1))); // R2

    AST_SAMPLE_STORED: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> head_data == $past(sample_in)); // R2

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> (acc == '0 && tap_idx == '0 && busy)); // R2

    AST_TAP_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && tap_idx != LAST && !sample_stb) |=> tap_idx == IDX_W'($past(tap_idx) + IDX_W'(1))); // R3

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !(busy && tap_idx == LAST) |=> $stable(filt_out)); // R6

    AST_LOAD_SUM: assert property (@(posedge clk) disable iff (rst)
        (busy && tap_idx == LAST) |=> filt_out == $past(acc)); // R8
endmodule

bind fir_seq_lowpass fir_seq_lowpass_chk #(
    .SW(SW), .AW(AW), .IDX_W(IDX_W), .PTR_W(PTR_W), .TAPS(TAPS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_stb (sample_stb),
    .sample_in  (sample_in),
    .head_ptr   (head_ptr),
    .head_data  (head_data),
    .tap_idx    (tap_idx),
    .busy       (busy),
    .acc        (acc),
    .filt_out   (filt_out)
);

// File: tb/fir_seq_lowpass_test.sv
module fir_seq_lowpass_test;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sample_stb = 1'b0;
    logic signed [7:0] sample_in = '0;
    logic signed [17:0] filt_out;

    int checks = 0;
    int errors = 0;
    int xs [0:1023];
    int nx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fir_seq_lowpass uut (
        .clk        (clk),
        .rst        (rst),
        .sample_stb (sample_stb),
        .sample_in  (sample_in),
        .filt_out   (filt_out)
    );

    // Coefficient values as listed in R5.
    function automatic int ref_coef(input int k);
        int h;
        int half [16] = '{-1, -1, -2, -3, -4, -3, 0, 6, 15, 27, 42, 58, 73, 85, 94, 97};
        if (k < 0 || k > 30) return 0;
        h = (k <= 15) ? k : 30 - k;
        return half[h];
    endfunction

    function automatic int ref_sum();
        int s = 0;
        for (int k = 0; k < 31; k++)
            if (nx - 1 - k >= 0) s += ref_coef(k) * xs[nx - 1 - k];
        return s;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the strobe edge.
    task automatic push(input int v);
        sample_stb = 1'b1;
        sample_in  = 8'(v);
        @(posedge clk);
        @(negedge clk);
        sample_stb = 1'b0;
        xs[nx] = v;
        nx++;
    endtask

    task automatic wait_result();
        repeat (32) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        int prev, exp_a, v;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset output", int'(filt_out), 0);

        // Positive unit impulse, then zeros (R7, R4)
        push(1);
        wait_result();
        check("R7 impulse tap0", int'(filt_out), ref_coef(0));
        for (int k = 1; k <= 31; k++) begin
            push(0);
            wait_result();
            check($sformatf("R7 impulse k=%0d", k), int'(filt_out), ref_sum());
        end

        // Negative full-scale impulse exercises signed multiply (R3, R5)
        push(-128);
        repeat (16) @(posedge clk);
        @(negedge clk);
        check("R6 held during accumulation", int'(filt_out), 0);
        wait_result();
        check("R3 signed tap0", int'(filt_out), -128 * ref_coef(0));
        for (int k = 1; k <= 30; k++) begin
            push(0);
            wait_result();
            check($sformatf("R5 neg impulse k=%0d", k), int'(filt_out), ref_sum());
        end

        // Random samples beyond ring depth (R4)
        for (int n = 0; n < 80; n++) begin
            v = int'($urandom_range(0, 255)) - 128;
            if (n % 17 == 0) v = 127;
            if (n % 19 == 0) v = -128;
            prev = int'(filt_out);
            push(v);
            repeat (20) @(posedge clk);
            @(negedge clk);
            check("R6 output stable mid-sum", int'(filt_out), prev);
            repeat (12) @(posedge clk);
            @(negedge clk);
            check("R4 random convolution", int'(filt_out), ref_sum());
        end

        // Strobe on the load edge (R8)
        push(55);
        exp_a = ref_sum();
        repeat (31) @(posedge clk);
        @(negedge clk);
        push(-77);
        check("R8 load with new strobe", int'(filt_out), exp_a);
        wait_result();
        check("R8 following sum", int'(filt_out), ref_sum());

        // Strobe mid-accumulation (R9)
        prev = int'(filt_out);
        push(100);
        repeat (10) @(negedge clk);
        push(-30);
        check("R9 output kept on restart", int'(filt_out), prev);
        wait_result();
        check("R9 restarted sum uses both", int'(filt_out), ref_sum());

        // Reset mid-stream clears history (R1)
        push(90);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears output", int'(filt_out), 0);
        nx = 0;
        push(3);
        wait_result();
        check("R1 history cleared", int'(filt_out), 3 * ref_coef(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule